// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block follows each instruction through the latches of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and keeps the pipeline's exceptions precise. A fault found in fetch, decode or execute does not act where it is found. The fault is marked on the instruction's own latch entry and moves with it. The memory stage is the single commit point. Data memory and the register file are only written from the memory and writeback stages, so any instruction that has not yet passed the memory stage can still be cancelled with no trace left.

When a marked instruction reaches the memory stage, the controller takes the exception. In that same cycle it blocks the instruction's memory write and stops its register write from reaching writeback. It also empties every younger latch and discards the fetch arriving in that cycle. The PC of the faulting instruction and a two-bit cause code are saved, and fetch is steered to a fixed handler address. An older instruction that is already in writeback completes as normal.

An external interrupt request is taken at an instruction boundary, just ahead of the instruction in the memory stage. The handler can then either abort the program or resume from the saved PC. The handler code itself and the memory system are outside this block.

Top module: `cmt_commit_ctrl`

## Requirements
- R1: After reset, all pipeline latches are empty. No write enable and no `take` is asserted, and `epc` and `cause` read zero.
- R2: An instruction fetched with `f_valid` at clock edge k that meets no exception drives `m_mem_we` (its decode-time memory write enable) in the cycle after edge k+2, with `m_pc` equal to its PC. It drives `w_reg_we` (its decode-time register write enable) one cycle later, with `w_pc` equal to its PC.
- R3: Fault sources and cause codes: a fetch PC with bits [1:0] not zero gives cause 3. `d_undef`, for the instruction in decode, gives cause 1. `e_divzero`, for the instruction in execute, gives cause 2. Only the first fault marked on an instruction is kept.
- R4: A marked instruction is taken exactly in the cycle it occupies the memory stage. In that cycle `m_mem_we` is low, and it never asserts `w_reg_we`.
- R5: On a take, every instruction younger than the one in the memory stage, including the fetch offered in that cycle, never asserts `m_mem_we` or `w_reg_we`.
- R6: The instruction in writeback during a take still asserts its `w_reg_we`.
- R7: From the cycle after a take, `epc` holds the PC of the instruction in the memory stage at the take and `cause` holds its code. Both hold their value until the next take.
- R8: `take` is high for one cycle per taken event, and during it `redirect_pc` equals the `HANDLER_PC` parameter.
- R9: When several instructions in flight are marked, only the oldest (the one in the memory stage) is taken. The younger marked ones are flushed and never cause a take of their own.
- R10: With `irq` high, a valid unmarked instruction in the memory stage, and no marked instruction in decode or execute, an interrupt is taken with cause 0. `epc` gets the PC of that instruction, and its writes are suppressed.
- R11: While a marked instruction waits in the fetch/decode or decode/execute latch, `irq` is not taken. The synchronous exception is taken first, and `irq` can be taken after that.
- R12: `irq` has no effect while the memory stage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_valid | input | 1 | An instruction is fetched this cycle |
| f_pc | input | 32 | PC of the fetched instruction |
| d_undef | input | 1 | Decode finds the opcode in the decode stage undefined |
| d_mem_we | input | 1 | Decoded memory write enable for the decode-stage instruction |
| d_reg_we | input | 1 | Decoded register write enable for the decode-stage instruction |
| e_divzero | input | 1 | Execute-stage instruction divides by zero |
| irq | input | 1 | External interrupt request (level) |
| m_mem_we | output | 1 | Gated data memory write enable, memory stage |
| m_pc | output | 32 | PC in the memory stage |
| w_reg_we | output | 1 | Gated register file write enable, writeback stage |
| w_pc | output | 32 | PC in the writeback stage |
| take | output | 1 | Exception or interrupt taken this cycle |
| redirect_pc | output | 32 | Fetch target when `take` is high |
| epc | output | 32 | Saved PC of the boundary instruction |
| cause | output | 2 | Saved cause code (0 irq, 1 undefined, 2 arithmetic, 3 misaligned) |

## Verification
The hardest case to reach from the ports is an interrupt that has to wait. That needs a clean instruction in the memory stage while a younger instruction, already marked, sits in decode or execute and `irq` is high. The bench builds this by fetching a clean instruction and then an undefined one straight behind it, with `irq` held high across the whole run. The interrupt must wait one cycle, the exception must win, and the interrupt must be taken once clean instructions arrive again. A second run places two marked instructions back to back, so that the younger one has to disappear without a take of its own.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;

    localparam int PC_W   = 32;
    localparam int NSTAGE = 4;   // fd, de, em, mw latches
    localparam int S_FD   = 0;
    localparam int S_DE   = 1;
    localparam int S_EM   = 2;
    localparam int S_MW   = 3;

    typedef enum logic [1:0] {
        CAUSE_IRQ      = 2'd0,
        CAUSE_UNDEF    = 2'd1,
        CAUSE_ARITH    = 2'd2,
        CAUSE_MISALIGN = 2'd3
    } cause_e;

    typedef struct packed {
        logic            valid;
        logic [PC_W-1:0] pc;
        logic            mem_we;
        logic            reg_we;
        logic            exc;
        cause_e          cause;
    } slot_t;

    function automatic slot_t empty_slot();
        slot_t s;
        s.valid  = 1'b0;
        s.pc     = '0;
        s.mem_we = 1'b0;
        s.reg_we = 1'b0;
        s.exc    = 1'b0;
        s.cause  = CAUSE_IRQ;
        return s;
    endfunction

    // first fault detected wins; later detections are dropped
    function automatic slot_t mark_fault(slot_t s, logic hit, cause_e c);
        slot_t r;
        r = s;
        if (s.valid && !s.exc && hit) begin
            r.exc   = 1'b1;
            r.cause = c;
        end
        return r;
    endfunction

endpackage

// File: rtl/cmt_stage_reg.sv
`timescale 1ns/1ps
module cmt_stage_reg
    import cmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  slot_t d,
    output slot_t q
);
    always_ff @(posedge clk) begin
        if (rst || flush) q <= empty_slot();
        else              q <= d;
    end
endmodule

// File: rtl/cmt_take_ctrl.sv
`timescale 1ns/1ps
module cmt_take_ctrl
    import cmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  slot_t           em_slot,
    input  logic            young_pend,
    input  logic            irq,
    output logic            take,
    output cause_e          take_cause,
    output logic [PC_W-1:0] take_pc
);
    logic take_sync;
    logic take_irq;

    always_comb begin
        take_sync  = em_slot.valid && em_slot.exc;
        take_irq   = irq && em_slot.valid && !em_slot.exc && !young_pend;
        take       = take_sync || take_irq;
        take_cause = take_sync ? em_slot.cause : CAUSE_IRQ;
        take_pc    = em_slot.pc;
    end

    // R12
    irq_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !em_slot.valid |-> !take);

    // R11
    irq_defer_chk: assert property (@(posedge clk) disable iff (rst)
        (young_pend && !em_slot.exc) |-> !take);
endmodule

// File: rtl/cmt_epc_reg.sv
`timescale 1ns/1ps
module cmt_epc_reg
    import cmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  cause_e          take_cause,
    input  logic [PC_W-1:0] take_pc,
    output logic [PC_W-1:0] epc,
    output cause_e          cause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            epc   <= '0;
            cause <= CAUSE_IRQ;
        end else if (take) begin
            epc   <= take_pc;
            cause <= take_cause;
        end
    end

    // R7
    epc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> ($stable(epc) && $stable(cause)));
endmodule

// File: rtl/cmt_commit_ctrl.sv
`timescale 1ns/1ps
module cmt_commit_ctrl
    import cmt_pkg::*;
#(
    parameter logic [31:0] HANDLER_PC = 32'h0000_0080
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        f_valid,
    input  logic [31:0] f_pc,
    input  logic        d_undef,
    input  logic        d_mem_we,
    input  logic        d_reg_we,
    input  logic        e_divzero,
    input  logic        irq,
    output logic        m_mem_we,
    output logic [31:0] m_pc,
    output logic        w_reg_we,
    output logic [31:0] w_pc,
    output logic        take,
    output logic [31:0] redirect_pc,
    output logic [31:0] epc,
    output logic [1:0]  cause
);
    slot_t  st_d [NSTAGE];
    slot_t  st_q [NSTAGE];
    logic   young_pend;
    cause_e take_cause;
    logic [PC_W-1:0] take_pc;
    cause_e cause_q;

    always_comb begin
        slot_t fs;
        slot_t ds;
        fs        = empty_slot();
        fs.valid  = f_valid;
        fs.pc     = f_pc;
        fs.exc    = f_valid && (f_pc[1:0] != 2'b00);
        fs.cause  = CAUSE_MISALIGN;
        st_d[S_FD] = fs;

        ds        = st_q[S_FD];
        ds.mem_we = d_mem_we;
        ds.reg_we = d_reg_we;
        st_d[S_DE] = mark_fault(ds, d_undef, CAUSE_UNDEF);

        st_d[S_EM] = mark_fault(st_q[S_DE], e_divzero, CAUSE_ARITH);
        st_d[S_MW] = st_q[S_EM];
    end

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        cmt_stage_reg i_reg (
            .clk  (clk),
            .rst  (rst),
            .flush(take),
            .d    (st_d[g]),
            .q    (st_q[g])
        );
    end

    assign young_pend = (st_q[S_FD].valid && st_q[S_FD].exc) ||
                        (st_q[S_DE].valid && st_q[S_DE].exc);

    cmt_take_ctrl i_take (
        .clk       (clk),
        .rst       (rst),
        .em_slot   (st_q[S_EM]),
        .young_pend(young_pend),
        .irq       (irq),
        .take      (take),
        .take_cause(take_cause),
        .take_pc   (take_pc)
    );

    cmt_epc_reg i_epc (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .take_cause(take_cause),
        .take_pc   (take_pc),
        .epc       (epc),
        .cause     (cause_q)
    );

    assign cause       = cause_q;
    assign m_mem_we    = st_q[S_EM].valid && st_q[S_EM].mem_we && !st_q[S_EM].exc && !take;
    assign m_pc        = st_q[S_EM].pc;
    assign w_reg_we    = st_q[S_MW].valid && st_q[S_MW].reg_we;
    assign w_pc        = st_q[S_MW].pc;
    assign redirect_pc = HANDLER_PC;

    // R4
    no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !w_reg_we);

    // R5
    flush_young_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (!st_q[S_FD].valid && !st_q[S_DE].valid && !st_q[S_EM].valid));

    // R7
    epc_capture_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (epc == $past(m_pc)));

    // R2
    mem_we_valid_chk: assert property (@(posedge clk) disable iff (rst)
        m_mem_we |-> st_q[S_EM].valid);
endmodule

// File: tb/test_cmt_commit_ctrl.sv
`timescale 1ns/1ps
module test_cmt_commit_ctrl;

    localparam logic [31:0] HANDLER = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst;
    logic        f_valid, d_undef, d_mem_we, d_reg_we, e_divzero, irq;
    logic [31:0] f_pc;
    logic        m_mem_we, w_reg_we, take;
    logic [31:0] m_pc, w_pc, redirect_pc, epc;
    logic [1:0]  cause;

    always #2 clk = ~clk;

    cmt_commit_ctrl #(.HANDLER_PC(HANDLER)) i_cmt_commit_ctrl (
        .clk(clk), .rst(rst), .f_valid(f_valid), .f_pc(f_pc),
        .d_undef(d_undef), .d_mem_we(d_mem_we), .d_reg_we(d_reg_we),
        .e_divzero(e_divzero), .irq(irq),
        .m_mem_we(m_mem_we), .m_pc(m_pc), .w_reg_we(w_reg_we), .w_pc(w_pc),
        .take(take), .redirect_pc(redirect_pc), .epc(epc), .cause(cause)
    );

    typedef struct {
        bit        v;
        bit [31:0] pc;
        bit        mwe, rwe, undef, divz, irq;
    } instr_t;

    typedef struct {
        bit        v;
        bit [31:0] pc;
        bit        mwe, rwe, undef, divz, ex;
        int        cause;
    } mslot_t;

    instr_t prog[$];
    mslot_t ms[4];
    bit [31:0] exp_epc;
    int        exp_cause;
    int        errors = 0;
    int        checks = 0;
    int        takes  = 0;
    string     cur_req;

    task automatic chk(bit ok, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, expv);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < 4; i++) ms[i] = '{default: 0};
    endfunction

    function automatic instr_t mk(bit [31:0] pc, bit mwe, bit rwe,
                                  bit undef, bit divz, bit irqb);
        instr_t r;
        r.v = 1; r.pc = pc; r.mwe = mwe; r.rwe = rwe;
        r.undef = undef; r.divz = divz; r.irq = irqb;
        return r;
    endfunction

    function automatic instr_t bub(bit irqb);
        instr_t r;
        r = '{default: 0};
        r.irq = irqb;
        return r;
    endfunction

    task automatic run_prog(int drain);
        int left;
        left = drain;
        while (prog.size() > 0 || left > 0) begin
            instr_t in;
            bit e_take, e_mwe, e_rwe, pend, t_sync, t_irq;
            if (prog.size() > 0) in = prog.pop_front();
            else begin in = bub(0); left--; end
            f_valid   = in.v;
            f_pc      = in.pc;
            irq       = in.irq;
            d_undef   = ms[0].v && ms[0].undef;
            d_mem_we  = ms[0].mwe;
            d_reg_we  = ms[0].rwe;
            e_divzero = ms[1].v && ms[1].divz;
            #1;
            pend   = (ms[0].v && ms[0].ex) || (ms[1].v && ms[1].ex);
            t_sync = ms[2].v && ms[2].ex;
            t_irq  = in.irq && ms[2].v && !ms[2].ex && !pend;
            e_take = t_sync || t_irq;
            e_mwe  = ms[2].v && ms[2].mwe && !ms[2].ex && !e_take;
            e_rwe  = ms[3].v && ms[3].rwe;
            chk(take == e_take, "take", take, e_take);
            chk(m_mem_we == e_mwe, "m_mem_we", m_mem_we, e_mwe);
            chk(w_reg_we == e_rwe, "w_reg_we", w_reg_we, e_rwe);
            if (e_mwe) chk(m_pc == ms[2].pc, "m_pc", m_pc, ms[2].pc);
            if (e_rwe) chk(w_pc == ms[3].pc, "w_pc", w_pc, ms[3].pc);
            if (e_take) chk(redirect_pc == HANDLER, "redirect_pc (R8)", redirect_pc, HANDLER);
            chk(epc == exp_epc, "epc (R7)", epc, exp_epc);
            chk(int'(cause) == exp_cause, "cause (R7)", cause, exp_cause);
            @(posedge clk);
            if (e_take) begin
                takes++;
                exp_epc   = ms[2].pc;
                exp_cause = t_sync ? ms[2].cause : 0;
                model_clear();
            end else begin
                ms[3] = ms[2];
                ms[2] = ms[1];
                if (ms[2].v && !ms[2].ex && ms[2].divz) begin ms[2].ex = 1; ms[2].cause = 2; end
                ms[1] = ms[0];
                if (ms[1].v && !ms[1].ex && ms[1].undef) begin ms[1].ex = 1; ms[1].cause = 1; end
                ms[0] = '{default: 0};
                ms[0].v = in.v; ms[0].pc = in.pc; ms[0].mwe = in.mwe; ms[0].rwe = in.rwe;
                ms[0].undef = in.undef; ms[0].divz = in.divz;
                if (in.v && in.pc[1:0] != 2'b00) begin ms[0].ex = 1; ms[0].cause = 3; end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t0;
        rst = 1; f_valid = 0; f_pc = 0; d_undef = 0; d_mem_we = 0;
        d_reg_we = 0; e_divzero = 0; irq = 0;
        model_clear();
        exp_epc = 0; exp_cause = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        cur_req = "R1";
        chk(take == 0, "take", take, 0);
        chk(m_mem_we == 0, "m_mem_we", m_mem_we, 0);
        chk(w_reg_we == 0, "w_reg_we", w_reg_we, 0);
        chk(epc == 0, "epc", epc, 0);
        chk(cause == 0, "cause", cause, 0);

        // R2: clean stream, mixed write enables
        cur_req = "R2";
        for (int i = 0; i < 8; i++)
            prog.push_back(mk(32'h100 + 4*i, i[0], i[1], 0, 0, 0));
        run_prog(6);

        // R3: misaligned fetch; R4/R5/R6 write suppression around it
        cur_req = "R3 R4 R5 R6 misaligned";
        t0 = takes;
        prog.push_back(mk(32'h200, 1, 1, 0, 0, 0));
        prog.push_back(mk(32'h206, 1, 1, 0, 0, 0));
        prog.push_back(mk(32'h208, 1, 1, 0, 0, 0));
        prog.push_back(mk(32'h20c, 1, 1, 0, 0, 0));
        prog.push_back(mk(32'h210, 1, 1, 0, 0, 0));
        run_prog(6);
        chk(epc == 32'h206, "epc misaligned", epc, 32'h206);
        chk(cause == 3, "cause misaligned", cause, 3);
        chk(takes - t0 == 1, "take count", takes - t0, 1);

        cur_req = "R3 R4 undefined";
        prog.push_back(mk(32'h300, 1, 1, 0, 0, 0));
        prog.push_back(mk(32'h304, 1, 1, 1, 1, 0));
        prog.push_back(mk(32'h308, 1, 0, 0, 0, 0));
        run_prog(6);
        chk(cause == 1, "cause undef kept over divzero", cause, 1);

        cur_req = "R3 R8 divzero";
        prog.push_back(mk(32'h400, 0, 1, 0, 1, 0));
        prog.push_back(mk(32'h404, 1, 1, 0, 0, 0));
        run_prog(6);
        chk(cause == 2, "cause divzero", cause, 2);
        chk(epc == 32'h400, "epc divzero", epc, 32'h400);

        // R9: two marked instructions back to back
        cur_req = "R9";
        t0 = takes;
        prog.push_back(mk(32'h500, 1, 1, 0, 1, 0));
        prog.push_back(mk(32'h505, 1, 1, 0, 0, 0));
        prog.push_back(mk(32'h508, 1, 1, 1, 0, 0));
        run_prog(6);
        chk(takes - t0 == 1, "single take", takes - t0, 1);
        chk(epc == 32'h500, "epc oldest", epc, 32'h500);

        // R10: plain interrupt
        cur_req = "R10";
        prog.push_back(mk(32'h600, 1, 1, 0, 0, 0));
        prog.push_back(mk(32'h604, 1, 1, 0, 0, 0));
        prog.push_back(mk(32'h608, 1, 1, 0, 0, 0));
        prog.push_back(mk(32'h60c, 1, 1, 0, 0, 1));
        run_prog(6);
        chk(cause == 0, "cause irq", cause, 0);
        chk(epc == 32'h600, "epc irq", epc, 32'h600);

        // R11: irq deferred behind a marked younger instruction
        cur_req = "R11";
        t0 = takes;
        prog.push_back(mk(32'h700, 1, 1, 0, 0, 1));
        prog.push_back(mk(32'h704, 1, 1, 1, 0, 1));
        prog.push_back(bub(1));
        prog.push_back(bub(1));
        prog.push_back(bub(1));
        prog.push_back(mk(32'h710, 1, 1, 0, 0, 1));
        prog.push_back(mk(32'h714, 1, 1, 0, 0, 1));
        prog.push_back(bub(1));
        prog.push_back(bub(1));
        run_prog(6);
        chk(takes - t0 == 2, "exception then irq", takes - t0, 2);
        chk(cause == 0, "final cause irq", cause, 0);
        chk(epc == 32'h710, "final epc", epc, 32'h710);

        // R12: irq with empty memory stage
        cur_req = "R12";
        t0 = takes;
        for (int i = 0; i < 6; i++) prog.push_back(bub(1));
        run_prog(2);
        chk(takes - t0 == 0, "no take", takes - t0, 0);
        chk(epc == 32'h710, "epc unchanged", epc, 32'h710);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule